// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the line sync, frame sync, data-enable and pixel coordinates that a parallel RGB panel needs. Software programs it through a small word-addressed register file. Horizontal and vertical timing are given as absolute positions inside the line and the frame:

- a total,
- a sync pulse width,
- the first active position,
- the position just past the active window.

Leading and trailing margins are not programmed as widths. The display start is the sync width plus the leading margin. The display end is the start plus the resolution. The total is the end plus the trailing margin.

Two counters step through each line and each frame while the block runs. Each of the three panel strobes has its own active-low option. A configuration bit moves every panel-facing output onto the falling edge of the pixel clock, which delays it by half a cycle.

Software can ask for a clean shutdown. The current frame then runs to its last pixel, the outputs drop to their idle levels, and a sticky status bit confirms that the block has stopped. Two sticky event flags mark the start and end of each frame. Each flag has its own interrupt enable, and the two masked flags are combined into one interrupt line.

Top module: `lcd_timing`

## Requirements
- R1: Registers are word indexed. The register at index 3 packs the line total in bits 31:16 and the frame total (in lines) in bits 15:0. The registers at index 4 (horizontal) and 5 (vertical) each hold the window start in bits 31:16 and the window end in bits 15:0. Every register reads back what was written to its stored fields. Unstored bits read zero.
- R2: The line-sync width at index 1 and the frame-sync width at index 2 keep only bits 9:0 of a write. All higher bits read back as zero.
- R3: Control register index 6 has run-enable in bit 3 and stop-request in bit 4. Writing enable=1 with stop-request=0 while stopped has the following effect:
  - the pixel position reads (0,0) after the second clock edge following the write edge;
  - the column then rises by one per clock and wraps to 0 after total-1;
  - the line rises by one at each column wrap and wraps to 0 after frame total-1.
- R4: The line sync is active while the column is below the line-sync width. The frame sync is active while the line is below the frame-sync width.
- R5: Data-enable is active only while column >= horizontal start, column < horizontal end, line >= vertical start, and line < vertical end.
- R6: Configuration index 0 sets the polarity of the three strobes, each active low when its bit is 1:
  - bit 11 for line sync;
  - bit 8 for frame sync;
  - bit 9 for data-enable.
  While stopped, every strobe sits at its inactive level.
- R7: With configuration bit 10 set, the strobes and the position update on the falling clock edge. Sampled just after a rising edge, they show the values of the previous cycle.
- R8: A stop request lets the running frame reach column total-1 on line total-1. On the next edge the block stops: strobes go inactive, the position returns to (0,0), and status index 7 bit 0 is set.
- R9: Status flags are sticky. A write to index 7 clears every flag whose data bit is 0 and keeps every flag whose data bit is 1.
- R10: Status bit 1 (start of frame) sets when the line counter wraps to 0 during normal running. It does not set on the wrap that ends a stop. Status bit 2 (end of frame) sets after the last column of the last active line, that is column hEnd-1 on line vEnd-1.
- R11: The interrupt output is high when status bit 1 is set with control bit 12 set, or when status bit 2 is set with control bit 13 set.
- R12: Clearing enable while running stops the block at the next edge. Outputs go inactive and the position returns to (0,0), but status bit 0 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| lcdHsync | output | 1 | Line sync with polarity applied |
| lcdVsync | output | 1 | Frame sync with polarity applied |
| lcdDe | output | 1 | Data-enable with polarity applied |
| pixX | output | 16 | Current column |
| pixY | output | 16 | Current line |
| irq | output | 1 | Masked frame-event interrupt |

## Verification
The bench targets the moment the stop takes effect. A design that stopped at the first line wrap, or one frame late, would set the stopped bit on the wrong cycle, and the cycle compare would catch it. It also checks that the stopping wrap leaves the start-of-frame flag clear; a design that set it there would raise a spurious interrupt after shutdown. The falling-edge mode is compared against the previous cycle's expected values, so a design that ignored bit 10 or delayed the strobes by a full cycle would mismatch on every transition. The bench also covers the boundary columns of the active window, the write-zero-to-clear of each flag on its own, the 10-bit truncation of the sync widths, and an abrupt enable clear, which must not report a graceful stop.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // register word indices
  localparam int A_CFG  = 0;
  localparam int A_HSW  = 1;
  localparam int A_VSW  = 2;
  localparam int A_TOT  = 3;
  localparam int A_HWIN = 4;
  localparam int A_VWIN = 5;
  localparam int A_CTL  = 6;
  localparam int A_STS  = 7;

  // configuration bits
  localparam int B_VS_LOW = 8;
  localparam int B_DE_LOW = 9;
  localparam int B_FALL   = 10;
  localparam int B_HS_LOW = 11;

  // control bits
  localparam int B_EN     = 3;
  localparam int B_STOPRQ = 4;
  localparam int B_SOFEN  = 12;
  localparam int B_EOFEN  = 13;

  // status bits
  localparam int B_STOPPED = 0;
  localparam int B_SOF     = 1;
  localparam int B_EOF     = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} lcdt_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic hsLow;
    logic vsLow;
    logic deLow;
    logic fallEdge;
  } lcdt_strobe_t;
endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int SW = 10,
  localparam int CW = DW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          frameEnd,
  input  logic          eofHit,
  output lcdt_strobe_t  strb,
  output logic [SW-1:0] hSyncW,
  output logic [SW-1:0] vSyncW,
  output logic [CW-1:0] hTotal,
  output logic [CW-1:0] vTotal,
  output logic [CW-1:0] hStart,
  output logic [CW-1:0] hEnd,
  output logic [CW-1:0] vStart,
  output logic [CW-1:0] vEnd,
  output logic          stsStopped,
  output logic          stsSof,
  output logic          irq
);
  logic [3:0]    cfgPol;
  logic [DW-1:0] totR, hWinR, vWinR;
  logic          ctlEn, ctlStop, ctlSofEn, ctlEofEn;
  lcdt_state_t   state, stateNx;
  logic          stopSet, sofHit, stsEof;
  logic          wrSts;

  assign hTotal = totR[DW-1:CW];
  assign vTotal = totR[CW-1:0];
  assign hStart = hWinR[DW-1:CW];
  assign hEnd   = hWinR[CW-1:0];
  assign vStart = vWinR[DW-1:CW];
  assign vEnd   = vWinR[CW-1:0];

  assign wrSts = regWe && (regAddr == AW'(A_STS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPol   <= '0;
      hSyncW   <= '0;
      vSyncW   <= '0;
      totR     <= '0;
      hWinR    <= '0;
      vWinR    <= '0;
      ctlEn    <= 1'b0;
      ctlStop  <= 1'b0;
      ctlSofEn <= 1'b0;
      ctlEofEn <= 1'b0;
    end else if (regWe) begin
      case (regAddr)
        AW'(A_CFG):  cfgPol <= regWdata[B_HS_LOW:B_VS_LOW];
        AW'(A_HSW):  hSyncW <= regWdata[SW-1:0];
        AW'(A_VSW):  vSyncW <= regWdata[SW-1:0];
        AW'(A_TOT):  totR   <= regWdata;
        AW'(A_HWIN): hWinR  <= regWdata;
        AW'(A_VWIN): vWinR  <= regWdata;
        AW'(A_CTL): begin
          ctlEn    <= regWdata[B_EN];
          ctlStop  <= regWdata[B_STOPRQ];
          ctlSofEn <= regWdata[B_SOFEN];
          ctlEofEn <= regWdata[B_EOFEN];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      AW'(A_CFG):  regRdata[B_HS_LOW:B_VS_LOW] = cfgPol;
      AW'(A_HSW):  regRdata[SW-1:0] = hSyncW;
      AW'(A_VSW):  regRdata[SW-1:0] = vSyncW;
      AW'(A_TOT):  regRdata = totR;
      AW'(A_HWIN): regRdata = hWinR;
      AW'(A_VWIN): regRdata = vWinR;
      AW'(A_CTL): begin
        regRdata[B_EN]     = ctlEn;
        regRdata[B_STOPRQ] = ctlStop;
        regRdata[B_SOFEN]  = ctlSofEn;
        regRdata[B_EOFEN]  = ctlEofEn;
      end
      AW'(A_STS): begin
        regRdata[B_STOPPED] = stsStopped;
        regRdata[B_SOF]     = stsSof;
        regRdata[B_EOF]     = stsEof;
      end
      default: ;
    endcase
  end

  // run / drain sequencing
  always_comb begin
    stateNx = state;
    stopSet = 1'b0;
    case (state)
      ST_IDLE: if (ctlEn && !ctlStop) stateNx = ST_RUN;
      ST_RUN: begin
        if (!ctlEn) stateNx = ST_IDLE;
        else if (ctlStop) begin
          if (frameEnd) begin
            stateNx = ST_IDLE;
            stopSet = 1'b1;
          end else stateNx = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!ctlEn) stateNx = ST_IDLE;
        else if (frameEnd) begin
          stateNx = ST_IDLE;
          stopSet = 1'b1;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  assign sofHit = (state == ST_RUN) && ctlEn && !ctlStop && frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      stsStopped <= 1'b0;
      stsSof     <= 1'b0;
      stsEof     <= 1'b0;
    end else begin
      state      <= stateNx;
      stsStopped <= (stsStopped && !(wrSts && !regWdata[B_STOPPED])) || stopSet;
      stsSof     <= (stsSof && !(wrSts && !regWdata[B_SOF])) || sofHit;
      stsEof     <= (stsEof && !(wrSts && !regWdata[B_EOF])) || eofHit;
    end
  end

  assign strb.run      = (state != ST_IDLE);
  assign strb.hsLow    = cfgPol[B_HS_LOW - B_VS_LOW];
  assign strb.vsLow    = cfgPol[0];
  assign strb.deLow    = cfgPol[B_DE_LOW - B_VS_LOW];
  assign strb.fallEdge = cfgPol[B_FALL - B_VS_LOW];

  assign irq = (stsSof && ctlSofEn) || (stsEof && ctlEofEn);
endmodule

// File: rtl/lcdt_path.sv
module lcdt_path
  import lcdt_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 10,
  localparam int OW = 3 + 2 * CW
) (
  input  logic          clk,
  input  logic          rstN,
  input  lcdt_strobe_t  strb,
  input  logic [SW-1:0] hSyncW,
  input  logic [SW-1:0] vSyncW,
  input  logic [CW-1:0] hTotal,
  input  logic [CW-1:0] vTotal,
  input  logic [CW-1:0] hStart,
  input  logic [CW-1:0] hEnd,
  input  logic [CW-1:0] vStart,
  input  logic [CW-1:0] vEnd,
  output logic          frameEnd,
  output logic          eofHit,
  output logic [CW-1:0] hCnt,
  output logic [CW-1:0] vCnt,
  output logic          hsOut,
  output logic          vsOut,
  output logic          deOut,
  output logic [CW-1:0] xOut,
  output logic [CW-1:0] yOut
);
  logic          lineEnd;
  logic          hsRaw, vsRaw, deRaw;
  logic [OW-1:0] riseVec, fallVec, outVec;

  assign lineEnd  = strb.run && (hCnt == hTotal - CW'(1));
  assign frameEnd = lineEnd && (vCnt == vTotal - CW'(1));
  assign eofHit   = strb.run && (hCnt == hEnd - CW'(1)) && (vCnt == vEnd - CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!strb.run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + CW'(1);
    end else begin
      hCnt <= hCnt + CW'(1);
    end
  end

  assign hsRaw = strb.run && (hCnt < CW'(hSyncW));
  assign vsRaw = strb.run && (vCnt < CW'(vSyncW));
  assign deRaw = strb.run && (hCnt >= hStart) && (hCnt < hEnd) &&
                 (vCnt >= vStart) && (vCnt < vEnd);

  assign riseVec = {hsRaw ^ strb.hsLow, vsRaw ^ strb.vsLow, deRaw ^ strb.deLow, hCnt, vCnt};

  // half-cycle retime for the falling-edge option
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallVec <= '0;
    else       fallVec <= riseVec;
  end

  assign outVec = strb.fallEdge ? fallVec : riseVec;
  assign {hsOut, vsOut, deOut, xOut, yOut} = outVec;
endmodule

// File: rtl/lcd_timing.sv
module lcd_timing
  import lcdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int SW = 10,
  localparam int CW = DW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          lcdHsync,
  output logic          lcdVsync,
  output logic          lcdDe,
  output logic [CW-1:0] pixX,
  output logic [CW-1:0] pixY,
  output logic          irq
);
  lcdt_strobe_t  strb;
  logic [SW-1:0] hSyncW, vSyncW;
  logic [CW-1:0] hTotal, vTotal, hStart, hEnd, vStart, vEnd;
  logic [CW-1:0] hCnt, vCnt;
  logic          frameEnd, eofHit, stsStopped, stsSof;

  lcdt_ctrl #(.DW(DW), .AW(AW), .SW(SW)) u_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata,
    .frameEnd, .eofHit, .strb, .hSyncW, .vSyncW,
    .hTotal, .vTotal, .hStart, .hEnd, .vStart, .vEnd,
    .stsStopped, .stsSof, .irq
  );

  lcdt_path #(.CW(CW), .SW(SW)) u_path (
    .clk, .rstN, .strb, .hSyncW, .vSyncW,
    .hTotal, .vTotal, .hStart, .hEnd, .vStart, .vEnd,
    .frameEnd, .eofHit, .hCnt, .vCnt,
    .hsOut(lcdHsync), .vsOut(lcdVsync), .deOut(lcdDe),
    .xOut(pixX), .yOut(pixY)
  );
endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          run,
  input logic          stsStopped,
  input logic          stsSof,
  input logic [CW-1:0] hCnt,
  input logic [CW-1:0] vCnt,
  input logic [CW-1:0] hTotal,
  input logic [CW-1:0] pixX,
  input logic [CW-1:0] pixY,
  input logic          wrZeroStop
);
  // R8: a graceful stop is reported exactly when running ends
  assert_stop_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsStopped) |-> ($past(run) && !run));

  // R8: once stopped and idle for a cycle, the position rests at (0,0)
  assert_stopped_home_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stsStopped && !run && $past(!run)) |-> (pixX == '0 && pixY == '0));

  // R9: the stopped flag only falls after a status write with bit 0 low
  assert_sticky_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stsStopped) |-> $past(wrZeroStop));

  // R3: a fresh run begins at the origin
  assert_start_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> (hCnt == '0 && vCnt == '0));

  // R3: inside a line the column steps by one
  assert_column_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && ($past(hCnt) != $past(hTotal) - CW'(1)))
      |-> (hCnt == $past(hCnt) + CW'(1)));

  // R10: start-of-frame flag rises only with the counters at the origin
  assert_sof_origin_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsSof) |-> (hCnt == '0 && vCnt == '0));
endmodule

bind lcd_timing lcdt_chk #(.CW(CW)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .run(strb.run),
  .stsStopped(stsStopped),
  .stsSof(stsSof),
  .hCnt(hCnt),
  .vCnt(vCnt),
  .hTotal(hTotal),
  .pixX(pixX),
  .pixY(pixY),
  .wrZeroStop(regWe && (regAddr == AW'(lcdt_pkg::A_STS)) && !regWdata[lcdt_pkg::B_STOPPED])
);

// File: tb/lcd_timing_tb.sv
module lcd_timing_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rstN, regWe;
  logic [2:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic        lcdHsync, lcdVsync, lcdDe, irq;
  logic [15:0] pixX, pixY;

  lcd_timing u_dut (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata,
    .lcdHsync, .lcdVsync, .lcdDe, .pixX, .pixY, .irq
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [31:0] mCfg, mHsw, mVsw, mTot, mHwin, mVwin, mCtl;
  logic        mStop, mSof, mEof;
  int          mState, mH, mV;
  logic [34:0] prevOut, curOut;
  bit          live = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [34:0] modelOut();
    bit run;
    bit hs, vs, de;
    int hS, hE, vS, vE;
    run = (mState != 0);
    hS = int'(mHwin[31:16]); hE = int'(mHwin[15:0]);
    vS = int'(mVwin[31:16]); vE = int'(mVwin[15:0]);
    hs = run && (mH < int'(mHsw));
    vs = run && (mV < int'(mVsw));
    de = run && mH >= hS && mH < hE && mV >= vS && mV < vE;
    return {hs ^ mCfg[11], vs ^ mCfg[8], de ^ mCfg[9], 16'(mH), 16'(mV)};
  endfunction

  function automatic logic [31:0] modelRead(input int a);
    case (a)
      0: return mCfg & 32'h0000_0F00;
      1: return mHsw;
      2: return mVsw;
      3: return mTot;
      4: return mHwin;
      5: return mVwin;
      6: return mCtl & 32'h0000_3018;
      default: return {29'd0, mEof, mSof, mStop};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCfg = 0; mHsw = 0; mVsw = 0; mTot = 0; mHwin = 0; mVwin = 0; mCtl = 0;
      mStop = 0; mSof = 0; mEof = 0; mState = 0; mH = 0; mV = 0;
      curOut = modelOut(); prevOut = curOut;
    end else begin
      bit run, en, rq, lineEnd, frameEnd, eofHit, sofHit, stopSet;
      int hT, vT, ns;
      prevOut = modelOut();
      run = (mState != 0);
      en = mCtl[3]; rq = mCtl[4];
      hT = int'(mTot[31:16]); vT = int'(mTot[15:0]);
      lineEnd  = run && (mH == hT - 1);
      frameEnd = lineEnd && (mV == vT - 1);
      eofHit   = run && (mH == int'(mHwin[15:0]) - 1) && (mV == int'(mVwin[15:0]) - 1);
      sofHit   = (mState == 1) && en && !rq && frameEnd;
      stopSet  = 0;
      ns = mState;
      case (mState)
        0: if (en && !rq) ns = 1;
        1: if (!en) ns = 0;
           else if (rq) begin
             if (frameEnd) begin ns = 0; stopSet = 1; end
             else ns = 2;
           end
        default: if (!en) ns = 0;
                 else if (frameEnd) begin ns = 0; stopSet = 1; end
      endcase
      if (!run) begin mH = 0; mV = 0; end
      else if (lineEnd) begin mH = 0; mV = frameEnd ? 0 : mV + 1; end
      else mH = mH + 1;
      if (regWe && regAddr == 3'd7) begin
        mStop = mStop & regWdata[0];
        mSof  = mSof & regWdata[1];
        mEof  = mEof & regWdata[2];
      end
      mStop = mStop | stopSet;
      mSof  = mSof | sofHit;
      mEof  = mEof | eofHit;
      if (regWe) begin
        case (regAddr)
          3'd0: mCfg = regWdata;
          3'd1: mHsw = {22'd0, regWdata[9:0]};
          3'd2: mVsw = {22'd0, regWdata[9:0]};
          3'd3: mTot = regWdata;
          3'd4: mHwin = regWdata;
          3'd5: mVwin = regWdata;
          3'd6: mCtl = regWdata;
          default: ;
        endcase
      end
      mState = ns;
      curOut = modelOut();
      live = 1;
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #2;
    if (live && rstN) begin
      logic [34:0] e;
      string mode;
      e = mCfg[10] ? prevOut : curOut;
      mode = mCfg[10] ? "R7" : "R6";
      chk({"R4 hsync ", mode}, 32'(lcdHsync), 32'(e[34]));
      chk({"R4 vsync ", mode}, 32'(lcdVsync), 32'(e[33]));
      chk({"R5 de ", mode}, 32'(lcdDe), 32'(e[32]));
      chk({"R3 position ", mode}, {pixX, pixY}, e[31:0]);
      chk("R11 irq", 32'(irq), 32'((mSof && mCtl[12]) || (mEof && mCtl[13])));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'(a); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input int a, input string req);
    @(negedge clk);
    regAddr = 3'(a);
    #1;
    chk(req, regRdata, modelRead(a));
  endtask

  task automatic rdLit(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = 3'(a);
    #1;
    chk(req, regRdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // reset state
    rdLit(7, 32'h0, "R9 status after reset");
    chk("R6 idle hsync", 32'(lcdHsync), 32'h0);

    // R1/R2 programming and readback
    wr(1, 32'hFFFF_F402);
    rdLit(1, 32'h0000_0002, "R2 hsync width truncation");
    wr(2, 32'h0000_0001);
    wr(3, 32'h000A_0006);
    wr(4, 32'h0003_0008);
    wr(5, 32'h0002_0005);
    rdLit(3, 32'h000A_0006, "R1 totals packing");
    rdLit(4, 32'h0003_0008, "R1 horizontal window");
    rdChk(5, "R1 vertical window");
    wr(0, 32'hFFFF_FFFF);
    rdLit(0, 32'h0000_0F00, "R1 config stored bits");
    wr(0, 32'h0);

    // R3 start from origin
    wr(6, 32'h0000_3008);
    @(posedge clk); #2;
    chk("R3 start column", 32'(pixX), 32'h0);
    chk("R3 start line", 32'(pixY), 32'h0);
    chk("R4 hsync at column 0", 32'(lcdHsync), 32'h1);
    @(posedge clk); #2;
    chk("R3 column step", 32'(pixX), 32'h1);
    idle(130);
    rdLit(7, 32'h0000_0006, "R10 both frame flags after two frames");
    rdChk(6, "R1 control readback");

    // R9 selective clear
    wr(7, 32'h0000_0002);
    rdChk(7, "R9 eof cleared sof kept");
    wr(7, 32'h0);
    rdChk(7, "R9 status cleared");
    idle(40);

    // R6 polarity, R7 falling edge
    wr(0, 32'h0000_0B00);
    idle(70);
    wr(0, 32'h0000_0400);
    idle(70);
    wr(0, 32'h0000_0F00);
    idle(70);
    wr(0, 32'h0);
    idle(25);

    // R8 graceful stop mid-frame
    wr(7, 32'h0);
    wr(6, 32'h0000_3018);
    begin
      int n = 0;
      while (n < 200) begin
        @(negedge clk);
        regAddr = 3'd7;
        #1;
        if (regRdata[0]) break;
        n++;
      end
      chk("R8 stop reported", 32'(regRdata[0]), 32'h1);
    end
    rdChk(7, "R10 no sof on stop wrap");
    idle(2);
    chk("R8 column home", 32'(pixX), 32'h0);
    chk("R8 de inactive", 32'(lcdDe), 32'h0);
    idle(5);
    rdLit(7, {29'd0, mEof, 1'b0, 1'b1}, "R8 stopped still flagged");

    // R9 stopped flag clear, R3 restart
    wr(7, 32'h0000_0006);
    rdChk(7, "R9 stopped cleared");
    wr(6, 32'h0000_0008);
    idle(23);

    // R12 abrupt stop
    wr(6, 32'h0);
    idle(3);
    chk("R12 hsync inactive", 32'(lcdHsync), 32'h0);
    chk("R12 column home", 32'(pixX), 32'h0);
    rdLit(7, {29'd0, mEof, mSof, 1'b0}, "R12 no stopped flag");
    idle(5);
    finishRun();
  end
endmodule